// File: doc/BRIEF.md
# EPROM Pulse Programming Sequencer

This block programs and checks a one-time-programmable code memory through that memory's parallel programming pins. A host hands it one request at a time over a valid/ready handshake. Each request names a 14-bit address, an expected byte, a key byte and a decrypt flag, and says whether to write the byte or only verify it.

A write puts the address and data on the memory pins. It then turns on the programming-voltage enable and fires a fixed train of timed active-low pulses on the program strobe. After the train it turns the voltage enable off again and verifies the same byte on its own. A verify lowers a read strobe while the voltage enable is off. After an access delay it samples the returned byte and compares it with the expected byte. When decrypt is set, the returned byte is first XNORed with the key. The block ends every request with a one-cycle done pulse, a pass flag and the decoded byte.

All timing is counted in clock cycles. The counts come from a clock-frequency parameter and microsecond parameters for the pulse width and the gaps.

Top module: `eprom_pulse_prog`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the done pulse has ended.
- R2: A write drives `prog_n` low exactly PULSE_COUNT times (default 25). Each low pulse lasts PULSE_CYC = (CLK_HZ/1e6)*PULSE_US cycles, with GAP_CYC = (CLK_HZ/1e6)*GAP_US cycles high between pulses.
- R3: `vpp_en` rises exactly GAP_CYC cycles before the first falling edge of `prog_n`. It stays high through the whole pulse train and is low at all other times. `prog_n` is never low while `vpp_en` is low.
- R4: During a write, `addr_lo` carries address bits 7:0, `addr_hi` carries bits 13:8, `prog_data` carries the data byte, and `prog_data_oe` is high while the pulses are issued.
- R5: `rd_n` goes low only while `vpp_en` is low. `mem_rdata` is sampled ACCESS_CYC cycles after `rd_n` falls, on the edge that ends the read.
- R6: Without decrypt, `rd_byte` is the sampled byte, and `pass` is 1 exactly when it equals the request's expected byte.
- R7: With decrypt set (and ENC_EN=1), `rd_byte` is the sampled byte XNOR the request key. `pass` compares that decoded byte with the expected byte.
- R8: Every write ends with an automatic verify of the same address. Every request, write or verify, ends with `done` high for exactly one cycle, with `pass` and `rd_byte` valid from that cycle until the next request.
- R9: While reset is low, including in the middle of a pulse train, `prog_n` and `rd_n` are high, `vpp_en` and `done` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = program then verify, 0 = verify only |
| req_addr | input | 14 | Byte address |
| req_data | input | 8 | Byte to program and expected verify value |
| req_key | input | 8 | XNOR key for decrypt |
| req_decrypt | input | 1 | Undo XNOR scrambling during compare |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Compare result of last request |
| rd_byte | output | 8 | Decoded byte of last read |
| addr_lo | output | 8 | Address bits 7:0 to memory |
| addr_hi | output | 6 | Address bits 13:8 to memory |
| prog_data | output | 8 | Data byte to memory |
| prog_data_oe | output | 1 | Enable for the data driver |
| prog_n | output | 1 | Active-low program strobe |
| vpp_en | output | 1 | Programming-voltage enable |
| rd_n | output | 1 | Active-low read strobe |
| mem_rdata | input | 8 | Byte returned by memory |

## Verification
A wrong state code or wrong timer load shows up at the strobe pins during the very request it affects. The bench measures the width of each pulse, the number of pulses, and the lead time of the voltage enable. A pulse-counter fault changes the pulse count seen at the pins before `done`. A sampling-time fault hands back a byte that is not yet valid, so `rd_byte` is wrong at the done pulse of the same request. Decrypt and plain paths are checked against a memory model that stores bytes and scrambles them, including a stuck bit and a wrong key.

// File: rtl/pps_pkg.sv
package pps_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_VPUP   = 3'd2,
      ST_PULSE  = 3'd3,
      ST_PGAP   = 3'd4,
      ST_VDN    = 3'd5,
      ST_READ   = 3'd6,
      ST_FINISH = 3'd7
   } seq_state_t;
endpackage

// File: rtl/pps_timer.sv
module pps_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   a_r2_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load) && $past(cnt) != '0) |-> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pps_compare.sv
module pps_compare #(
   parameter int DATA_W = 8,
   parameter bit ENC_EN = 1'b1
) (
   input  logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] key,
   input  logic              decrypt,
   input  logic [DATA_W-1:0] expect_byte,
   output logic [DATA_W-1:0] decoded,
   output logic              match
);
   generate
      if (ENC_EN) begin : g_xnor
         assign decoded = decrypt ? ~(rdata ^ key) : rdata;
      end else begin : g_plain
         logic unused_ok;
         assign unused_ok = decrypt ^ (^key);
         assign decoded   = rdata;
      end
   endgenerate

   assign match = (decoded == expect_byte);
endmodule

// File: rtl/eprom_pulse_prog.sv
module eprom_pulse_prog
   import pps_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int PULSE_US    = 100,
   parameter int GAP_US      = 10,
   parameter int PULSE_COUNT = 25,
   parameter int ACCESS_CYC  = 3,
   parameter int ADDR_W      = 14,
   parameter int LO_W        = 8,
   parameter int DATA_W      = 8,
   parameter bit ENC_EN      = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_write,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_data,
   input  logic [DATA_W-1:0]        req_key,
   input  logic                     req_decrypt,
   output logic                     done,
   output logic                     pass,
   output logic [DATA_W-1:0]        rd_byte,
   output logic [LO_W-1:0]          addr_lo,
   output logic [ADDR_W-LO_W-1:0]   addr_hi,
   output logic [DATA_W-1:0]        prog_data,
   output logic                     prog_data_oe,
   output logic                     prog_n,
   output logic                     vpp_en,
   output logic                     rd_n,
   input  logic [DATA_W-1:0]        mem_rdata
);
   localparam int CYC_PER_US = CLK_HZ / 1_000_000;
   localparam int PULSE_CYC  = CYC_PER_US * PULSE_US;
   localparam int GAP_CYC    = CYC_PER_US * GAP_US;
   localparam int MAX_A      = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
   localparam int MAX_D      = (MAX_A > ACCESS_CYC) ? MAX_A : ACCESS_CYC;
   localparam int TW         = $clog2(MAX_D + 1);
   localparam int PCW        = $clog2(PULSE_COUNT + 1);

   generate
      if (CYC_PER_US < 1)       begin : g_bad_clk $error("CLK_HZ below 1 MHz"); end
      if (PULSE_CYC < 1)        begin : g_bad_pw  $error("pulse width is zero"); end
      if (GAP_CYC < 1)          begin : g_bad_gap $error("gap is zero"); end
      if (PULSE_COUNT < 1)      begin : g_bad_np  $error("pulse count is zero"); end
      if (ACCESS_CYC < 1)       begin : g_bad_acc $error("access delay is zero"); end
      if (LO_W >= ADDR_W)       begin : g_bad_aw  $error("address split invalid"); end
   endgenerate

   seq_state_t             state, nstate;
   logic                   tmr_load, tmr_zero;
   logic [TW-1:0]          tmr_val;
   logic [PCW-1:0]         pcnt;
   logic [ADDR_W-1:0]      q_addr;
   logic [DATA_W-1:0]      q_data, q_key, dec_byte;
   logic                   q_dec, q_wr, cmp_match;
   logic                   accept;

   assign accept = req_valid && (state == ST_IDLE);

   pps_timer #(.W(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
   );

   pps_compare #(.DATA_W(DATA_W), .ENC_EN(ENC_EN)) u_cmp (
      .rdata(mem_rdata), .key(q_key), .decrypt(q_dec), .expect_byte(q_data),
      .decoded(dec_byte), .match(cmp_match)
   );

   always_comb begin
      nstate   = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state)
         ST_IDLE: if (req_valid) begin
            nstate = ST_SETUP; tmr_load = 1'b1; tmr_val = TW'(GAP_CYC - 1);
         end
         ST_SETUP: if (tmr_zero) begin
            tmr_load = 1'b1;
            if (q_wr) begin nstate = ST_VPUP; tmr_val = TW'(GAP_CYC - 1); end
            else      begin nstate = ST_READ; tmr_val = TW'(ACCESS_CYC - 1); end
         end
         ST_VPUP: if (tmr_zero) begin
            nstate = ST_PULSE; tmr_load = 1'b1; tmr_val = TW'(PULSE_CYC - 1);
         end
         ST_PULSE: if (tmr_zero) begin
            nstate = ST_PGAP; tmr_load = 1'b1; tmr_val = TW'(GAP_CYC - 1);
         end
         ST_PGAP: if (tmr_zero) begin
            tmr_load = 1'b1;
            if (pcnt == PCW'(PULSE_COUNT)) begin nstate = ST_VDN; tmr_val = TW'(GAP_CYC - 1); end
            else begin nstate = ST_PULSE; tmr_val = TW'(PULSE_CYC - 1); end
         end
         ST_VDN: if (tmr_zero) begin
            nstate = ST_READ; tmr_load = 1'b1; tmr_val = TW'(ACCESS_CYC - 1);
         end
         ST_READ:   if (tmr_zero) nstate = ST_FINISH;
         ST_FINISH: nstate = ST_IDLE;
         default:   nstate = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         pcnt    <= '0;
         q_addr  <= '0;
         q_data  <= '0;
         q_key   <= '0;
         q_dec   <= 1'b0;
         q_wr    <= 1'b0;
         pass    <= 1'b0;
         rd_byte <= '0;
      end else begin
         state <= nstate;
         if (accept) begin
            pcnt   <= '0;
            q_addr <= req_addr;
            q_data <= req_data;
            q_key  <= req_key;
            q_dec  <= req_decrypt;
            q_wr   <= req_write;
         end
         if (state == ST_PULSE && tmr_zero) pcnt <= pcnt + 1'b1;
         if (state == ST_READ && tmr_zero) begin
            pass    <= cmp_match;
            rd_byte <= dec_byte;
         end
      end
   end

   assign req_ready    = (state == ST_IDLE);
   assign done         = (state == ST_FINISH);
   assign vpp_en       = (state == ST_VPUP) || (state == ST_PULSE) || (state == ST_PGAP);
   assign prog_n       = (state != ST_PULSE);
   assign rd_n         = (state != ST_READ);
   assign prog_data_oe = q_wr && ((state == ST_SETUP) || vpp_en || (state == ST_VDN));
   assign prog_data    = q_data;
   assign addr_lo      = q_addr[LO_W-1:0];
   assign addr_hi      = q_addr[ADDR_W-1:LO_W];

   a_r3_strobe_needs_vpp: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_n |-> vpp_en);
   a_r3_vpp_leads_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog_n) |-> $past(vpp_en));
   a_r5_read_vpp_off: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !vpp_en);
   a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r2_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt <= PCW'(PULSE_COUNT));
   a_r4_oe_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_n |-> prog_data_oe);
endmodule

// File: tb/tb_eprom_pulse_prog.sv
module tb_eprom_pulse_prog;
   localparam int CLK_HZ = 1_000_000;
   localparam int PW     = 100;
   localparam int GAP    = 10;
   localparam int NP     = 25;
   localparam int ACC    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, req_decrypt = 1'b0;
   logic [13:0] req_addr = '0;
   logic [7:0]  req_data = '0, req_key = '0;
   logic req_ready, done, pass, prog_data_oe, prog_n, vpp_en, rd_n;
   logic [7:0] rd_byte, addr_lo, prog_data, mem_rdata;
   logic [5:0] addr_hi;

   always #10 clk = ~clk;

   eprom_pulse_prog #(.CLK_HZ(CLK_HZ), .PULSE_US(100), .GAP_US(10),
                      .PULSE_COUNT(NP), .ACCESS_CYC(ACC)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_data(req_data),
      .req_key(req_key), .req_decrypt(req_decrypt), .done(done), .pass(pass),
      .rd_byte(rd_byte), .addr_lo(addr_lo), .addr_hi(addr_hi),
      .prog_data(prog_data), .prog_data_oe(prog_data_oe), .prog_n(prog_n),
      .vpp_en(vpp_en), .rd_n(rd_n), .mem_rdata(mem_rdata)
   );

   int checks = 0, fails = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory model: bit 0 at low address 8'h23 is stuck at zero
   logic [7:0] mem [256];
   logic       m_enc = 1'b0;
   logic [7:0] m_key = '0;
   int         rd_cnt = 0;
   logic [7:0] m_val;

   assign m_val     = m_enc ? ~(mem[addr_lo] ^ m_key) : mem[addr_lo];
   assign mem_rdata = (rd_cnt >= ACC - 1) ? m_val : ~m_val;

   always @(posedge clk) rd_cnt <= rd_n ? 0 : rd_cnt + 1;

   // pin monitor
   int npulse, badw, lowrun, lead, lead_cap, rdviol;
   logic [13:0] cap_addr;
   logic [7:0]  cap_data;
   logic        cap_oe;

   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
         npulse = 0; badw = 0; lowrun = 0; lead = 0; lead_cap = 0; rdviol = 0;
      end else begin
         if (req_valid && req_ready) begin
            npulse = 0; badw = 0; lowrun = 0; lead = 0; lead_cap = 0; rdviol = 0;
         end
         if (!prog_n) begin
            if (lowrun == 0) begin
               npulse++;
               if (npulse == 1) begin
                  lead_cap = lead;
                  cap_addr = {addr_hi, addr_lo};
                  cap_data = prog_data;
                  cap_oe   = prog_data_oe;
                  mem[addr_lo] = prog_data & ((addr_lo == 8'h23) ? 8'hFE : 8'hFF);
               end
            end
            lowrun++;
         end else if (lowrun != 0) begin
            if (lowrun != PW) badw++;
            lowrun = 0;
         end
         if (!vpp_en) lead = 0;
         else if (prog_n && npulse == 0) lead++;
         if (!rd_n && vpp_en) rdviol++;
      end
   end

   // {wr, addr, data, key, dec, model_key, pass, rd_byte}
   localparam int NV = 9;
   localparam logic [48:0] VEC [NV] = '{
      {1'b1, 14'h0005, 8'h5A, 8'h00, 1'b0, 8'h00, 1'b1, 8'h5A},
      {1'b1, 14'h3F80, 8'hC3, 8'h00, 1'b0, 8'h00, 1'b1, 8'hC3},
      {1'b1, 14'h0123, 8'hA5, 8'h00, 1'b0, 8'h00, 1'b0, 8'hA4},
      {1'b1, 14'h1242, 8'h3C, 8'h96, 1'b1, 8'h96, 1'b1, 8'h3C},
      {1'b1, 14'h0777, 8'h81, 8'h00, 1'b1, 8'h3C, 1'b0, 8'hBD},
      {1'b0, 14'h0005, 8'h5A, 8'h00, 1'b0, 8'h00, 1'b1, 8'h5A},
      {1'b0, 14'h0005, 8'h5B, 8'h00, 1'b0, 8'h00, 1'b0, 8'h5A},
      {1'b0, 14'h0099, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'hFF},
      {1'b0, 14'h1242, 8'h3C, 8'h96, 1'b1, 8'h96, 1'b1, 8'h3C}
   };

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (150_000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: idle levels under reset and right after release
      check(prog_n && rd_n && !vpp_en && !done && req_ready, "R9 reset idle",
            {prog_n, rd_n, vpp_en, done, req_ready}, 5'b11001);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && prog_n && !vpp_en, "R9 idle after release",
            {req_ready, prog_n, vpp_en}, 3'b110);

      for (int v = 0; v < NV; v++) begin
         logic [48:0] e;
         int wait_n;
         e = VEC[v];
         req_write = e[48]; req_addr = e[47:34]; req_data = e[33:26];
         req_key = e[25:18]; req_decrypt = e[17]; m_key = e[16:9]; m_enc = e[17];
         req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
         check(!req_ready, "R1 ready low after accept", req_ready, 0);
         wait_n = 0;
         while (!done && wait_n < 10_000) begin
            @(negedge clk);
            wait_n++;
            if (wait_n == 40) check(!req_ready, "R1 ready low while busy", req_ready, 0);
         end
         check(done, "R8 done reached", done, 1);
         check(pass == e[8], "R6/R7 pass flag", pass, e[8]);
         check(rd_byte == e[7:0], e[17] ? "R7 decoded byte" : "R6 read byte", rd_byte, e[7:0]);
         check(rdviol == 0, "R5 read strobe with vpp", rdviol, 0);
         if (e[48]) begin
            check(npulse == NP, "R2 pulse count", npulse, NP);
            check(badw == 0, "R2 pulse width", badw, 0);
            check(lead_cap == GAP, "R3 vpp lead", lead_cap, GAP);
            check(cap_addr == e[47:34], "R4 address pins", cap_addr, e[47:34]);
            check(cap_data == e[33:26] && cap_oe, "R4 data pins", {cap_oe, cap_data}, {1'b1, e[33:26]});
         end else begin
            check(npulse == 0, "R8 verify issues no pulse", npulse, 0);
         end
         @(negedge clk);
         check(!done && req_ready, "R8 done one cycle", {done, req_ready}, 2'b01);
         check(!vpp_en, "R3 vpp off after op", vpp_en, 0);
      end

      // R9: reset in the middle of a pulse train
      req_write = 1'b1; req_addr = 14'h0010; req_data = 8'h11; req_decrypt = 1'b0;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (300) @(negedge clk);
      check(vpp_en, "R3 vpp high mid train", vpp_en, 1);
      rst_n = 1'b0;
      #1;
      check(prog_n && rd_n && !vpp_en && req_ready, "R9 reset mid train",
            {prog_n, rd_n, vpp_en, req_ready}, 4'b1101);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (GAP + 5) @(negedge clk);
      check(prog_n && !vpp_en && req_ready, "R9 stays idle after reset",
            {prog_n, vpp_en, req_ready}, 3'b101);
      finish_run();
   end
endmodule